// File: doc/BRIEF.md
# Memory-Mapped 16-Pin GPIO Port Controller

This block controls one general-purpose I/O port of 16 pins through a 32-byte register window on a simple memory-mapped bus. The bus carries an access strobe, a write flag, a byte address, a size bit, write data, and combinational read data with an error flag.

Software uses the window to do five things. It writes the output data register directly, or changes single bits through set and clear aliases. It changes pin directions, which are reachable only through set and clear aliases. It enables input buffers and peripheral function per pin. It stores a 32-bit pin-mux word.

Output levels are driven only on pins whose input buffer is disabled, and they are refreshed only by particular writes. Incoming levels are accepted only on pins that are configured for input. Accepted levels pass through a two-flop synchronizer before they appear at the input-level output.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every register reads 0, including the hidden direction register, and `pinOut` and `pinInSync` are 0.
- R2: The register at offset 0x1C must be accessed with `busSize`=1 (32 bits). Every other register must be accessed with `busSize`=0 (16 bits). An access of the wrong size raises `busErr` in its own cycle, returns 0 on `busRdata`, changes no register and leaves `pinOut` unchanged.
- R3: An access to an offset that is not a multiple of 4, or that is 0x20 or above, raises `busErr`, returns 0 and has no side effect. `busErr` is 0 whenever `busValid` is 0.
- R4: Offsets 0x00 (function enable), 0x04 (data) and 0x18 (input enable) are plain 16-bit storage; a write keeps `busWdata[15:0]` and a read returns it with bits 31:16 at 0. Offset 0x1C (mux) is plain 32-bit storage.
- R5: A write to 0x08 ORs the written value into data. A write to 0x0C clears every data bit that is written as 1. Reads of 0x04, 0x08 and 0x0C all return the current data value.
- R6: A write to 0x10 ORs bits into the hidden direction register, where 1 means output. A write to 0x14 clears every direction bit that is written as 1. Reads of 0x10 and 0x14 return the direction value.
- R7: At the clock edge that commits a write to 0x04, 0x08, 0x0C or 0x10, every pin whose input-enable bit is 0 takes the new data bit on `pinOut`. Pins whose input-enable bit is 1 hold their previous level.
- R8: Writes to 0x00, 0x14, 0x18 or 0x1C, and all reads, leave `pinOut` unchanged.
- R9: A pin is accepted when its direction bit is 0, its input-enable bit is 1 and its function-enable bit is 1. `pinInSync[i]` shows the level `pinIn[i]` had two clock edges earlier while the pin is accepted, and shows 0 while it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset within the window |
| busSize | input | 1 | 0 = 16-bit access, 1 = 32-bit access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| busErr | output | 1 | Invalid access indication, valid in the access cycle |
| pinIn | input | 16 | Incoming pin levels |
| pinOut | output | 16 | Driven pin levels |
| pinInSync | output | 16 | Synchronized levels of accepted pins |

## Verification
The assertions check properties that must hold on every cycle:
- `busErr` stays low without `busValid`, and read data is 0 whenever an error is flagged.
- An erroring access never moves `pinOut`, and no cycle without a write moves it either.
- `pinInSync` is never high on a pin that is not currently accepted.

Only the bench scenarios can show the following:
- The arithmetic of the set and clear aliases, and that the data and direction aliases read back the same value.
- Which pins a refresh actually updates, and that writes to function enable, direction clear, input enable and mux leave a stale `pinOut` stale.
- The two-edge input latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    IDX_FUNC  = 3'd0,
    IDX_DATA  = 3'd1,
    IDX_DSET  = 3'd2,
    IDX_DCLR  = 3'd3,
    IDX_DIRS  = 3'd4,
    IDX_DIRC  = 3'd5,
    IDX_INEN  = 3'd6,
    IDX_MUX   = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic    wrFunc;
    logic    wrData;
    logic    wrSet;
    logic    wrClr;
    logic    wrDirSet;
    logic    wrDirClr;
    logic    wrInen;
    logic    wrMux;
    logic    refresh;
    logic    rdEn;
    regIdx_e rdIdx;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSize,
  output portStrobe_t       strobe,
  output logic              busErr
);

  localparam int WIN_BITS = 5;

  logic    aligned;
  logic    inWindow;
  logic    sizeOk;
  logic    accOk;
  regIdx_e idx;

  always_comb begin
    idx      = regIdx_e'(busAddr[WIN_BITS-1:2]);
    aligned  = (busAddr[1:0] == 2'b00);
    inWindow = ((busAddr >> WIN_BITS) == '0);
    sizeOk   = (idx == IDX_MUX) ? busSize : !busSize;
    busErr   = busValid && !(aligned && inWindow && sizeOk);
    accOk    = busValid && !busErr;
  end

  always_comb begin
    strobe          = '0;
    strobe.rdIdx    = idx;
    strobe.rdEn     = accOk && !busWrite;
    if (accOk && busWrite) begin
      unique case (idx)
        IDX_FUNC: strobe.wrFunc   = 1'b1;
        IDX_DATA: strobe.wrData   = 1'b1;
        IDX_DSET: strobe.wrSet    = 1'b1;
        IDX_DCLR: strobe.wrClr    = 1'b1;
        IDX_DIRS: strobe.wrDirSet = 1'b1;
        IDX_DIRC: strobe.wrDirClr = 1'b1;
        IDX_INEN: strobe.wrInen   = 1'b1;
        IDX_MUX:  strobe.wrMux    = 1'b1;
        default:  ;
      endcase
    end
    strobe.refresh = strobe.wrData || strobe.wrSet || strobe.wrClr || strobe.wrDirSet;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= dIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int BUS_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinInSync,
  output logic [PIN_W-1:0] acceptMask
);

  localparam int PAD_W = BUS_W - PIN_W;

  logic [PIN_W-1:0] funcQ, dataQ, dirQ, inenQ;
  logic [BUS_W-1:0] muxQ;
  logic [PIN_W-1:0] dataNext, dirNext, wLow;
  logic [PIN_W-1:0] pinOutQ;
  logic [PIN_W-1:0] syncOut;

  assign wLow = busWdata[PIN_W-1:0];

  always_comb begin
    dataNext = dataQ;
    if (strobe.wrData) dataNext = wLow;
    if (strobe.wrSet)  dataNext = dataQ | wLow;
    if (strobe.wrClr)  dataNext = dataQ & ~wLow;
    dirNext = dirQ;
    if (strobe.wrDirSet) dirNext = dirQ | wLow;
    if (strobe.wrDirClr) dirNext = dirQ & ~wLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcQ <= '0;
      dataQ <= '0;
      dirQ  <= '0;
      inenQ <= '0;
      muxQ  <= '0;
    end else begin
      dataQ <= dataNext;
      dirQ  <= dirNext;
      if (strobe.wrFunc) funcQ <= wLow;
      if (strobe.wrInen) inenQ <= wLow;
      if (strobe.wrMux)  muxQ  <= busWdata;
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : gPin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           pinOutQ[i] <= 1'b0;
      else if (strobe.refresh && !inenQ[i]) pinOutQ[i] <= dataNext[i];
    end
    assign acceptMask[i] = !dirQ[i] && inenQ[i] && funcQ[i];
  end

  gpio_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_N)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinIn & acceptMask),
    .dOut (syncOut)
  );

  assign pinInSync = syncOut & acceptMask;
  assign pinOut    = pinOutQ;

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      unique case (strobe.rdIdx)
        IDX_FUNC:                     busRdata = {{PAD_W{1'b0}}, funcQ};
        IDX_DATA, IDX_DSET, IDX_DCLR: busRdata = {{PAD_W{1'b0}}, dataQ};
        IDX_DIRS, IDX_DIRC:           busRdata = {{PAD_W{1'b0}}, dirQ};
        IDX_INEN:                     busRdata = {{PAD_W{1'b0}}, inenQ};
        IDX_MUX:                      busRdata = muxQ;
        default:                      busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 16,
  parameter int BUS_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSize,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busErr,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinInSync
);

  portStrobe_t      strobe;
  logic [PIN_W-1:0] acceptMask;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .strobe   (strobe),
    .busErr   (busErr)
  );

  gpio_port_dp #(.PIN_W(PIN_W), .BUS_W(BUS_W), .SYNC_N(SYNC_N)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .pinIn      (pinIn),
    .pinOut     (pinOut),
    .pinInSync  (pinInSync),
    .acceptMask (acceptMask)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PIN_W = 16,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWrite,
  input logic [BUS_W-1:0] busRdata,
  input logic             busErr,
  input logic [PIN_W-1:0] pinOut,
  input logic [PIN_W-1:0] pinInSync,
  input logic [PIN_W-1:0] acceptMask
);

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> !busErr);                                                  // R3

  AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0));                                            // R2

  AST_ERR_PINS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busErr) |=> $stable(pinOut));                               // R2

  AST_IDLE_PINS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> $stable(pinOut));                            // R8

  AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (pinInSync & ~acceptMask) == '0);                                        // R9

endmodule

bind gpio_port_ctl gpio_port_chk #(.PIN_W(PIN_W), .BUS_W(BUS_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busRdata   (busRdata),
  .busErr     (busErr),
  .pinOut     (pinOut),
  .pinInSync  (pinInSync),
  .acceptMask (acceptMask)
);

// File: tb/tb_gpio_port_ctl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busSize = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic [15:0] pinInSync;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rd;
  logic        er;

  always #4 clk = ~clk;

  gpio_port_ctl dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .pinIn(pinIn),
    .pinOut(pinOut), .pinInSync(pinInSync)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic sz,
                        input logic [31:0] wd, output logic [31:0] r, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busSize = sz; busWdata = wd;
    #1;
    r = busRdata; e = busErr;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] v);
    access(1'b1, a, 1'b0, {16'h0, v}, rd, er);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic sz,
                       input logic [31:0] exp);
    access(1'b0, a, sz, 32'h0, rd, er);
    check(req, rd, exp);
  endtask

  task automatic testReset();
    rdChk("R1 func",  8'h00, 1'b0, 32'h0);
    rdChk("R1 data",  8'h04, 1'b0, 32'h0);
    rdChk("R1 dir",   8'h10, 1'b0, 32'h0);
    rdChk("R1 inen",  8'h18, 1'b0, 32'h0);
    rdChk("R1 mux",   8'h1C, 1'b1, 32'h0);
    check("R1 pinOut", {16'h0, pinOut}, 32'h0);
    check("R1 pinInSync", {16'h0, pinInSync}, 32'h0);
  endtask

  task automatic testStorage();
    access(1'b1, 8'h00, 1'b0, 32'hFFFF5A5A, rd, er);
    check("R4 func write err", {31'h0, er}, 32'h0);
    rdChk("R4 func readback", 8'h00, 1'b0, 32'h00005A5A);
    access(1'b1, 8'h1C, 1'b1, 32'hDEADBEEF, rd, er);
    rdChk("R4 mux readback", 8'h1C, 1'b1, 32'hDEADBEEF);
    wr16(8'h00, 16'h0000);
  endtask

  task automatic testSetClr();
    wr16(8'h04, 16'h00F0);
    wr16(8'h08, 16'h0301);
    rdChk("R5 set result via data", 8'h04, 1'b0, 32'h000003F1);
    wr16(8'h0C, 16'h0030);
    rdChk("R5 clr result via set alias", 8'h08, 1'b0, 32'h000003C1);
    rdChk("R5 clr alias reads data", 8'h0C, 1'b0, 32'h000003C1);
  endtask

  task automatic testDir();
    wr16(8'h10, 16'h8005);
    rdChk("R6 dirset readback", 8'h10, 1'b0, 32'h00008005);
    wr16(8'h14, 16'h0004);
    rdChk("R6 dirclr alias reads dir", 8'h14, 1'b0, 32'h00008001);
    wr16(8'h14, 16'hFFFF);
    rdChk("R6 dir cleared", 8'h10, 1'b0, 32'h0);
  endtask

  task automatic testRefresh();
    wr16(8'h18, 16'h0000);
    wr16(8'h04, 16'h1234);
    check("R7 data write drives all pins", {16'h0, pinOut}, 32'h1234);
    wr16(8'h18, 16'h00FF);
    check("R8 inen write no refresh", {16'h0, pinOut}, 32'h1234);
    wr16(8'h04, 16'hABCD);
    check("R7 inen pins hold", {16'h0, pinOut}, 32'hAB34);
    wr16(8'h0C, 16'h0F00);
    check("R7 clr refresh", {16'h0, pinOut}, 32'hA034);
    wr16(8'h18, 16'h0000);
    wr16(8'h14, 16'h0000);
    check("R8 dirclr no refresh", {16'h0, pinOut}, 32'hA034);
    wr16(8'h00, 16'h0000);
    access(1'b1, 8'h1C, 1'b1, 32'h0, rd, er);
    check("R8 func/mux no refresh", {16'h0, pinOut}, 32'hA034);
    wr16(8'h10, 16'h0000);
    check("R7 dirset refresh", {16'h0, pinOut}, 32'hA0CD);
  endtask

  task automatic testErrors();
    access(1'b1, 8'h04, 1'b1, 32'h00000000, rd, er);
    check("R2 data 32-bit err", {31'h0, er}, 32'h1);
    check("R2 no pin change", {16'h0, pinOut}, 32'hA0CD);
    rdChk("R2 data unchanged", 8'h04, 1'b0, 32'h0000A0CD);
    access(1'b0, 8'h1C, 1'b0, 32'h0, rd, er);
    check("R2 mux 16-bit err", {31'h0, er}, 32'h1);
    check("R2 err rdata zero", rd, 32'h0);
    access(1'b1, 8'h1C, 1'b0, 32'h12345678, rd, er);
    rdChk("R2 mux unchanged", 8'h1C, 1'b1, 32'h0);
    access(1'b1, 8'h20, 1'b0, 32'h0000FFFF, rd, er);
    check("R3 offset 0x20 err", {31'h0, er}, 32'h1);
    access(1'b1, 8'h06, 1'b0, 32'h0000FFFF, rd, er);
    check("R3 misaligned err", {31'h0, er}, 32'h1);
    rdChk("R3 no side effect", 8'h04, 1'b0, 32'h0000A0CD);
    check("R3 pins untouched", {16'h0, pinOut}, 32'hA0CD);
    #1;
    check("R3 idle no err", {31'h0, busErr}, 32'h0);
  endtask

  task automatic testInput();
    wr16(8'h18, 16'h0018);
    wr16(8'h00, 16'h0008);
    @(negedge clk);
    pinIn = 16'h0018;
    @(posedge clk); #1;
    check("R9 one edge not yet", {16'h0, pinInSync}, 32'h0);
    @(posedge clk); #1;
    check("R9 accepted after two edges", {16'h0, pinInSync}, 32'h0008);
    wr16(8'h10, 16'h0008);
    check("R9 output dir blocks", {16'h0, pinInSync}, 32'h0);
    wr16(8'h14, 16'h0008);
    repeat (2) @(posedge clk);
    #1;
    check("R9 reaccepted", {16'h0, pinInSync}, 32'h0008);
    wr16(8'h18, 16'h0010);
    check("R9 inen off blocks", {16'h0, pinInSync}, 32'h0);
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testStorage();
    testSetClr();
    testDir();
    testRefresh();
    testErrors();
    testInput();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule